// File: doc/BRIEF.md
# Receiver Error Logger with Sample Concealment

This block sits behind the front end of a digital audio receiver. Each cycle the receiver presents a vector of error conditions, such as parity, biphase coding, confidence, validity, lock loss and two CRC checks. A host-programmed enable register decides which of these conditions count. Enabled errors are latched into a status register whose bits stay set until the host reads them. The same enabled errors drive a live combined error line and a level interrupt.

The block also conditions the audio path. When a sample arrives in a cycle where an enabled, audio-relevant error is present, a hold-mode input decides what happens to it. The sample can be replaced by the last sample that went through unmodified, forced to zero, or passed on as it is. The two CRC errors are logged and raise the interrupt, but they never alter audio. A static select input chooses what the external error pin shows: the combined receiver error, or the raw non-validity condition.

Top module: `rx_err_guard`

## Requirements
- R1: After reset the status register, the enable register, `irq`, `rerr` and `out_valid` all read 0.
- R2: An error condition present in a cycle while its enable bit (`reg_addr`=1 register) is 1 sets its status bit at the next clock edge. Bit order: 0 parity, 1 biphase, 2 confidence, 3 validity, 4 unlock, 5 channel-status CRC, 6 Q-subcode CRC, 7 reserved.
- R3: A status bit stays set until a status read (`reg_rd`=1, `reg_addr`=0). That read returns the latched value and clears it at the same edge. An error that is present in the read cycle is still latched, so it shows on the following read.
- R4: An error whose enable bit is 0 is not logged, does not drive `rerr`, and does not alter the sample.
- R5: `rerr` is the combinational OR of the current error conditions ANDed with the enable bits. It is not latched.
- R6: `irq` is a level that is 1 whenever any status bit is set, and it drops after the read that clears them.
- R7: With `hold_mode`=1, a flagged sample is output as the most recent sample that went through unmodified. That register resets to 0, so repeated flagged samples all repeat the same value.
- R8: With `hold_mode`=2, a flagged sample is output as zero.
- R9: With `hold_mode`=0 or 3, a flagged sample is output unchanged.
- R10: The CRC errors (bits 5 and 6) never flag a sample, even when enabled, but they are still logged and still raise `irq`.
- R11: `err_pin` equals `rerr` when `err_pin_sel`=1. When `err_pin_sel`=0 it equals the raw validity condition (bit 3), whatever the enable bits are.
- R12: Bit 7 of the status and enable registers always reads 0.
- R13: Each input sample appears on `out_data` with `out_valid`=1 exactly one cycle after it was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt | input | 8 | Error conditions for this cycle |
| err_pin_sel | input | 1 | 1: pin shows combined error; 0: raw validity error |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears it) |
| reg_addr | input | 1 | 0 status, 1 enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Incoming sample |
| hold_mode | input | 2 | 0/3 pass, 1 repeat last, 2 zero |
| rerr | output | 1 | Live combined enabled error |
| err_pin | output | 1 | Selected external error indication |
| irq | output | 1 | Level interrupt, any status bit set |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Processed sample |

## Verification
A wrong status bit shows on the next status read and on `irq` one cycle after the error. A stuck or lost sticky bit shows as a wrong value on a second read. A bad read-clear shows up when an error arrives during a read, because the following read no longer returns it. A corrupted previous-sample register only shows on the next held sample, which may come many samples later. The scoreboard therefore places good samples between flagged ones and compares every output one cycle after its input.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;

    localparam int ERR_W = 8;

    localparam int ERR_PARITY  = 0;
    localparam int ERR_BIPHASE = 1;
    localparam int ERR_CONF    = 2;
    localparam int ERR_VALID   = 3;
    localparam int ERR_UNLOCK  = 4;
    localparam int ERR_CSCRC   = 5;
    localparam int ERR_QCRC    = 6;

    // bits that exist in hardware (bit 7 reserved)
    localparam logic [ERR_W-1:0] IMPL_BITS  = 8'h7F;
    // bits that may alter the audio sample (CRC errors excluded)
    localparam logic [ERR_W-1:0] AUDIO_BITS = 8'h1F;

    typedef enum logic [1:0] {
        HM_PASS  = 2'd0,
        HM_HOLD  = 2'd1,
        HM_MUTE  = 2'd2,
        HM_PASS3 = 2'd3
    } hold_mode_t;

    typedef enum logic {
        RA_STATUS = 1'b0,
        RA_ENABLE = 1'b1
    } reg_addr_t;

    typedef struct packed {
        logic             wr;
        logic             rd;
        reg_addr_t        addr;
        logic [ERR_W-1:0] wdata;
    } reg_req_t;

    function automatic logic [ERR_W-1:0] enabled_errs(
        input logic [ERR_W-1:0] ev,
        input logic [ERR_W-1:0] en
    );
        return ev & en & IMPL_BITS;
    endfunction

    function automatic logic touches_audio(input logic [ERR_W-1:0] act);
        return |(act & AUDIO_BITS);
    endfunction

endpackage

// File: rtl/rxerr_sticky_bank.sv
module rxerr_sticky_bank
    import rxerr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_req_t         req,
    input  logic [ERR_W-1:0] err_evt,
    output logic [ERR_W-1:0] stat_q,
    output logic [ERR_W-1:0] en_q,
    output logic [ERR_W-1:0] rdata
);
    logic rd_clear;
    logic en_write;

    assign rd_clear = req.rd && (req.addr == RA_STATUS);
    assign en_write = req.wr && (req.addr == RA_ENABLE);

    for (genvar i = 0; i < ERR_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[i] <= 1'b0;
                en_q[i]   <= 1'b0;
            end else begin
                // new event wins over the clear of the same edge
                stat_q[i] <= IMPL_BITS[i] &
                             ((stat_q[i] & ~rd_clear) | (err_evt[i] & en_q[i]));
                if (en_write)
                    en_q[i] <= IMPL_BITS[i] & req.wdata[i];
            end
        end
    end

    always_comb begin
        rdata = (req.addr == RA_ENABLE) ? en_q : stat_q;
    end

endmodule

// File: rtl/rxerr_conceal.sv
module rxerr_conceal
    import rxerr_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              flagged,
    input  hold_mode_t        mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] last_good_q;
    logic [DATA_W-1:0] result;
    logic              untouched;

    always_comb begin
        untouched = 1'b1;
        result    = in_data;
        if (flagged) begin
            unique case (mode)
                HM_HOLD: begin
                    result    = last_good_q;
                    untouched = 1'b0;
                end
                HM_MUTE: begin
                    result    = '0;
                    untouched = 1'b0;
                end
                default: begin
                    result    = in_data;
                    untouched = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            last_good_q <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= result;
                if (untouched)
                    last_good_q <= in_data;
            end
        end
    end

endmodule

// File: rtl/rx_err_guard.sv
module rx_err_guard
    import rxerr_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        err_evt,
    input  logic              err_pin_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [1:0]        hold_mode,
    output logic              rerr,
    output logic              err_pin,
    output logic              irq,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    reg_req_t         req;
    logic [ERR_W-1:0] stat_q;
    logic [ERR_W-1:0] en_q;
    logic [ERR_W-1:0] active;
    logic             flag;

    always_comb begin
        req.wr    = reg_wr;
        req.rd    = reg_rd;
        req.addr  = reg_addr_t'(reg_addr);
        req.wdata = reg_wdata;
    end

    rxerr_sticky_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .err_evt (err_evt),
        .stat_q  (stat_q),
        .en_q    (en_q),
        .rdata   (reg_rdata)
    );

    assign active  = enabled_errs(err_evt, en_q);
    assign flag    = touches_audio(active);
    assign rerr    = |active;
    assign err_pin = err_pin_sel ? rerr : err_evt[ERR_VALID];
    assign irq     = |stat_q;

    rxerr_conceal #(.DATA_W(DATA_W)) u_conceal (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (smp_valid),
        .in_data   (smp_data),
        .flagged   (flag),
        .mode      (hold_mode_t'(hold_mode)),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/rx_err_guard_chk.sv
module rx_err_guard_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        err_evt,
    input logic [7:0]        stat_q,
    input logic [7:0]        en_q,
    input logic              reg_rd,
    input logic              reg_addr,
    input logic              smp_valid,
    input logic [DATA_W-1:0] smp_data,
    input logic [1:0]        hold_mode,
    input logic              rerr,
    input logic              irq,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    logic [7:0] live_en;
    logic       audio_hit;
    assign live_en   = err_evt & en_q & 8'h7F;
    assign audio_hit = |(live_en & 8'h1F);

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (|live_en) |=> ((stat_q & $past(live_en)) == $past(live_en)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && !reg_addr) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    p_masked_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == 8'h00));

    p_live_r5: assert property (@(posedge clk) disable iff (rst)
        rerr |-> (|(err_evt & en_q)));

    p_irq_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|live_en));

    p_mute_r8: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && hold_mode == 2'd2 && audio_hit) |=> (out_valid && out_data == '0));

    p_crc_r10: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !audio_hit) |=> (out_data == $past(smp_data)));

    p_resv_r12: assert property (@(posedge clk) disable iff (rst)
        (stat_q[7] == 1'b0) && (en_q[7] == 1'b0));

endmodule

bind rx_err_guard rx_err_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .err_evt   (err_evt),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .hold_mode (hold_mode),
    .rerr      (rerr),
    .irq       (irq),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_rx_err_guard.sv
module tb_rx_err_guard;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    err_evt = '0;
    logic          err_pin_sel = 1'b1;
    logic          reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [1:0]    hold_mode = 2'd0;
    logic          rerr, err_pin, irq, out_valid;
    logic [DW-1:0] out_data;

    int            n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0]    cur_en = '0;
    logic [DW-1:0] good = '0;
    logic [DW-1:0] exp_q[$];
    int            cyc_q[$];
    bit            done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rx_err_guard #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .err_evt(err_evt), .err_pin_sel(err_pin_sel),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .smp_valid(smp_valid), .smp_data(smp_data), .hold_mode(hold_mode),
        .rerr(rerr), .err_pin(err_pin), .irq(irq),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected outputs one cycle after issue (R13)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R13 unexpected out_valid", 1, 0);
            end else begin
                check("R13 latency", cyc_q.pop_front(), cyc - 1);
                check("R7/R8/R9/R10 sample", out_data, exp_q.pop_front());
            end
        end
    end

    // driver: called at a negedge, returns at the next negedge
    task automatic send(logic [DW-1:0] d, logic [7:0] ev, string req);
        logic [7:0]    act;
        logic [DW-1:0] e;
        act = ev & cur_en & 8'h7F;
        e = d;
        if (|(act & 8'h1F)) begin
            if (hold_mode == 2'd1) e = good;
            else if (hold_mode == 2'd2) e = '0;
        end
        if (e == d) good = d;
        smp_valid = 1'b1; smp_data = d; err_evt = ev;
        exp_q.push_back(e); cyc_q.push_back(cyc);
        #1;
        check({req, " R5 rerr"}, rerr, |act);
        check({req, " R11 err_pin"}, err_pin, err_pin_sel ? |act : ev[3]);
        @(negedge clk);
        smp_valid = 1'b0; err_evt = '0;
    endtask

    task automatic rd_status(logic [7:0] exp, string req);
        reg_rd = 1'b1; reg_addr = 1'b0;
        #1;
        check(req, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_enable(logic [7:0] v);
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = v;
        cur_en = v & 8'h7F;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 status", reg_rdata, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 rerr", rerr, 0);
        check("R1 out_valid", out_valid, 0);
        reg_addr = 1'b1; #1;
        check("R1 enable", reg_rdata, 8'h00);
        reg_addr = 1'b0;
        @(negedge clk);

        // R4 all disabled: nothing logged, sample untouched
        hold_mode = 2'd1;
        send(24'h000123, 8'hFF, "R4");
        check("R4 irq", irq, 0);
        rd_status(8'h00, "R4 status");

        // R12 reserved bit
        wr_enable(8'hFF);
        reg_addr = 1'b1; #1;
        check("R12 enable readback", reg_rdata, 8'h7F);
        reg_addr = 1'b0;
        @(negedge clk);

        // R7 hold repeats last good, twice
        send(24'h111111, 8'h02, "R7");
        check("R6 irq", irq, 1);
        send(24'h222222, 8'h04, "R7");
        rd_status(8'h06, "R2 status");
        check("R6 irq after clear", irq, 0);
        rd_status(8'h00, "R3 second read");

        // R8 mute, then good sample updates hold source
        hold_mode = 2'd2;
        send(24'h000055, 8'h01, "R8");
        send(24'h000777, 8'h00, "R9 clean");
        hold_mode = 2'd1;
        send(24'h000888, 8'h10, "R7 after mute");

        // R9 pass modes
        hold_mode = 2'd0;
        send(24'hABCDEF, 8'h10, "R9 mode0");
        hold_mode = 2'd3;
        send(24'h13579B, 8'h08, "R9 mode3");
        hold_mode = 2'd1;
        send(24'h000999, 8'h01, "R7 after pass");
        rd_status(8'h19, "R2 mixed");

        // R10 CRC errors logged but audio untouched
        hold_mode = 2'd2;
        send(24'h0C0C0C, 8'h60, "R10");
        check("R10 irq", irq, 1);
        rd_status(8'h60, "R10 status");

        // R12 reserved event never latched
        send(24'h000001, 8'h80, "R12");
        rd_status(8'h00, "R12 status");

        // R3 error during the read cycle is kept
        send(24'h000002, 8'h00, "R3 prep");
        err_evt = 8'h01; @(negedge clk); err_evt = 8'h00;
        err_evt = 8'h08;
        rd_status(8'h01, "R3 read with new event");
        err_evt = 8'h00;
        rd_status(8'h08, "R3 event kept");
        rd_status(8'h00, "R3 cleared");

        // R4/R5 partial enable
        wr_enable(8'h01);
        send(24'h000003, 8'h02, "R4 masked");
        send(24'h000004, 8'h01, "R5 enabled");
        rd_status(8'h01, "R4 partial");

        // R11 pin select with validity disabled
        wr_enable(8'h00);
        err_pin_sel = 1'b0;
        send(24'h000005, 8'h08, "R11 sel0");
        err_pin_sel = 1'b1;
        send(24'h000006, 8'h08, "R11 sel1");

        repeat (2) @(negedge clk);
        check("R13 queue drained", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule